// File: doc/BRIEF.md
# Overlapping multicarrier PWM generator

This block drives one phase leg of a five-level clamped inverter. Each enabled clock is one modulation sample. A sample counter produces a sine reference and four triangular carriers of equal amplitude. The carriers are stacked so that neighbouring bands share half their height. The block compares the reference with every carrier and counts the carriers lying strictly below it. That count, minus two, is the output level. The level selects a switch pattern for four upper gates and their four complements.

Two inputs set the waveform. A modulation-index word scales the reference. A 2-bit arrangement select sets the phase relationship among the carriers: all in phase, the lower pair opposed to the upper pair, or each carrier inverted against its neighbour. Both values are taken only at a reference zero crossing, so the output never switches shape in the middle of a half wave. All pins are plain control or status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `mc_overlap_pwm`

## Requirements
- R1: While `rst` is high at a clock edge, the edge sets `level` to 0, `gate_hi` to 4'b1100 and `gate_lo` to 4'b0011, and moves the sample index back to 0. `rst` takes priority over `en`.
- R2: `level` is a signed 3-bit value from -2 to +2. It equals (number of carriers strictly below the reference) minus 2. It is registered: the edge that consumes sample n presents the level for sample n.
- R3: `gate_hi[i]` is on exactly when i + level + 2 >= 4. Bit 3 is the innermost upper switch and bit 0 the outermost. `gate_lo[i]` is always the complement of `gate_hi[i]`. Levels +2, +1, 0, -1 and -2 give `gate_hi` 1111, 1110, 1100, 1000 and 0000.
- R4: The carrier amplitude is 256 units. Carrier k (k = 0 at the bottom to k = 3 at the top) spans -320+128k to -64+128k, so the whole stack covers -320..+320. A non-inverted carrier starts at its low end at carrier phase 0, rises 16 units per sample to its top at phase 16, and falls back by phase 32. An inverted carrier is 256 minus that ramp, added to the same low end.
- R5: Sample index n runs 0..671, and carrier phase is n mod 32. That gives exactly 21 carrier periods per reference period. The reference is about (index/128)·320·sin(2πn/672), with an error of at most 2 units. It is exactly 0 at n = 0 and n = 336 and never negative for n < 336.
- R6: With arrangement 0, all four carriers are non-inverted.
- R7: With arrangement 1, carriers 0 and 1 are inverted and carriers 2 and 3 are not.
- R8: With arrangement 2, carriers 1 and 3 are inverted and carriers 0 and 2 are not.
- R9: Arrangement 3 behaves the same as arrangement 0.
- R10: While `en` is low, the sample index, `level` and all gates hold their values. The next enabled clock resumes from the held sample.
- R11: `arr_mode` and `mod_index` take effect only on an enabled clock whose sample index is 0 or 336. That sample already uses the new values. A change at any other time has no effect until the next such sample.
- R12: Index 128 reaches both ±2 levels in every arrangement. Index 0 holds the reference at 0. With index 0, arrangement 0 reaches only -1..+1, and arrangements 1 and 2 give level 0 at every sample that is not an exact tie.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance one modulation sample |
| arr_mode | input | 2 | Carrier phase arrangement select |
| mod_index | input | 8 | Modulation index, 128 = 1.0 |
| gate_hi | output | 4 | Upper switch gates, bit 3 innermost |
| gate_lo | output | 4 | Complementary lower switch gates |
| level | output | 3 | Signed output level code |

## Verification
The bench compares every sample against a floating-point model of the carrier stack. It skips only samples where the reference lies within 4 units of a carrier, because there rounding could legitimately flip one comparison. A wrongly inverted carrier, a mis-stacked band or a drifted 21:1 ratio shows up at once as level miscompares.

At index 0 the inverted arrangements must sit at level 0, while the in-phase one must swing to ±1. A design that swapped arrangements or inverted the wrong carriers would miss these extremes.

A mode change issued in the middle of a half wave must not take effect until sample 336. An early switch would drop the +2 excursion before the crossing.

A paused run must resume on the exact sample where it stopped. A counter that kept running under a low `en` would fall out of step with the model.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

  // Carrier phase arrangement selected by arr_mode.
  typedef enum logic [1:0] {
    ARR_SAME  = 2'd0,   // every carrier in phase
    ARR_SPLIT = 2'd1,   // lower pair opposed to upper pair
    ARR_ALT   = 2'd2,   // neighbours opposed
    ARR_RSVD  = 2'd3    // behaves as ARR_SAME
  } arr_e;

  localparam int NCAR  = 4;                  // carriers for five output levels
  localparam int CNT_W = $clog2(NCAR + 1);   // width of the "carriers below" count
  localparam int LVL_W = 3;                  // signed level code

  // Rational half-wave sine approximation, scaled to 2^frac.
  // h is the position within a half wave of length half.
  function automatic int unsigned half_sine_q(input int h, input int half, input int frac);
    longint num;
    longint den;
    num = longint'(16) * longint'(h) * longint'(half - h);
    den = longint'(5) * longint'(half) * longint'(half)
        - longint'(4) * longint'(h) * longint'(half - h);
    return int'(((num <<< frac) + den / 2) / den);
  endfunction

endpackage

// File: rtl/mc_timebase.sv
module mc_timebase #(
  parameter int CAR_LOG2 = 5,
  parameter int RATIO    = 21
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        en,
  output logic [$clog2(RATIO * (1 << CAR_LOG2))-1:0] phase,
  output logic [CAR_LOG2-1:0]                         car_ph,
  output logic                                        zc
);
  localparam int PERIOD = RATIO * (1 << CAR_LOG2);
  localparam int HALF   = PERIOD / 2;
  localparam int NW     = $clog2(PERIOD);

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (en)
      phase <= (phase == NW'(PERIOD - 1)) ? '0 : phase + 1'b1;
  end

  // Carrier phase is taken from the same counter, which locks the two rates.
  assign car_ph = phase[CAR_LOG2-1:0];
  assign zc     = (phase == '0) || (phase == NW'(HALF));

  // R5
  wrap_period_chk: assert property (@(posedge clk) disable iff (rst)
    (en && phase == NW'(PERIOD - 1)) |=> (phase == '0));

  // R10
  idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase));

endmodule

// File: rtl/mc_sine_ref.sv
module mc_sine_ref
  import mcpwm_pkg::*;
#(
  parameter int CAR_LOG2 = 5,
  parameter int RATIO    = 21,
  parameter int AC_LOG2  = 8,
  parameter int MI_W     = 8,
  parameter int MI_FRAC  = 7,
  parameter int SIN_FRAC = 14,
  parameter int RW       = 11
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [$clog2(RATIO * (1 << CAR_LOG2))-1:0] phase,
  input  logic [MI_W-1:0]                             mi,
  output logic signed [RW-1:0]                        ref_val
);
  localparam int PERIOD    = RATIO * (1 << CAR_LOG2);
  localparam int HALF      = PERIOD / 2;
  localparam int QN        = HALF / 2;
  localparam int NW        = $clog2(PERIOD);
  localparam int QW        = $clog2(QN + 1);
  localparam int AC        = 1 << AC_LOG2;
  localparam int HALF_SPAN = AC + AC / 4;
  localparam int PW        = MI_W + (AC_LOG2 + 1) + (SIN_FRAC + 1);
  localparam int SHIFT     = MI_FRAC + SIN_FRAC;

  // Quarter-wave magnitude table, filled at elaboration.
  logic [SIN_FRAC:0] qtab [QN+1];
  for (genvar i = 0; i <= QN; i++) begin : g_qtab
    localparam int unsigned VAL = half_sine_q(i, HALF, SIN_FRAC);
    assign qtab[i] = (SIN_FRAC + 1)'(VAL);
  end

  logic          neg;
  logic [NW-1:0] h;
  logic [NW-1:0] qi;
  logic [PW-1:0] prod;
  logic [RW-1:0] mag;

  always_comb begin
    neg  = (phase >= NW'(HALF));
    h    = neg ? (phase - NW'(HALF)) : phase;
    qi   = (h <= NW'(QN)) ? h : (NW'(HALF) - h);
    prod = PW'(mi) * PW'(HALF_SPAN) * PW'(qtab[qi[QW-1:0]]);
    mag  = RW'(prod >> SHIFT);
    ref_val = neg ? -$signed(mag) : $signed(mag);
  end

  // R5
  zero_cross_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == '0 || phase == NW'(HALF)) |-> (ref_val == '0));

  // R5
  pos_half_chk: assert property (@(posedge clk) disable iff (rst)
    (phase < NW'(HALF)) |-> (ref_val >= 0));

endmodule

// File: rtl/mc_carrier_bank.sv
module mc_carrier_bank
  import mcpwm_pkg::*;
#(
  parameter int CAR_LOG2 = 5,
  parameter int AC_LOG2  = 8,
  parameter int RW       = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  arr_e                 mode,
  input  logic [CAR_LOG2-1:0]  car_ph,
  input  logic signed [RW-1:0] ref_val,
  output logic [NCAR-1:0]      above,
  output logic [CNT_W-1:0]     n_above
);
  localparam int STEPS     = 1 << CAR_LOG2;
  localparam int HSTEPS    = STEPS / 2;
  localparam int AC        = 1 << AC_LOG2;
  localparam int HALF_SPAN = AC + AC / 4;
  localparam int SH        = AC_LOG2 - CAR_LOG2 + 1;   // log2 of the ramp step

  logic [CAR_LOG2:0] up;
  logic [AC_LOG2:0]  ramp;

  always_comb begin
    up   = (car_ph <= CAR_LOG2'(HSTEPS)) ? {1'b0, car_ph}
                                          : ((CAR_LOG2 + 1)'(STEPS) - {1'b0, car_ph});
    ramp = (AC_LOG2 + 1)'({up, {SH{1'b0}}});
  end

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    localparam int  BASE   = -HALF_SPAN + k * (AC / 2);
    localparam bit  IN_LOW = (k < NCAR / 2);
    localparam bit  ODD    = ((k % 2) == 1);
    logic                 inv;
    logic [AC_LOG2:0]     shape;
    logic signed [RW-1:0] car;

    always_comb begin
      unique case (mode)
        ARR_SPLIT: inv = IN_LOW;
        ARR_ALT:   inv = ODD;
        default:   inv = 1'b0;
      endcase
      shape = inv ? ((AC_LOG2 + 1)'(AC) - ramp) : ramp;
      car   = RW'(BASE) + $signed(RW'(shape));
    end

    assign above[k] = (ref_val > car);
  end

  always_comb begin
    n_above = '0;
    for (int k = 0; k < NCAR; k++)
      n_above = n_above + CNT_W'(above[k]);
  end

  // With every carrier in phase, a higher carrier always lies above a lower one.
  for (genvar k = 0; k < NCAR - 1; k++) begin : g_thermo
    // R6
    same_phase_thermo_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == ARR_SAME) |-> (!above[k+1] || above[k]));
  end

endmodule

// File: rtl/mc_gate_map.sv
module mc_gate_map
  import mcpwm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [LVL_W-1:0] lvl,
  output logic [NCAR-1:0]         gate_hi,
  output logic [NCAR-1:0]         gate_lo
);
  logic [LVL_W-1:0] on_cnt;

  assign on_cnt = LVL_W'(lvl + LVL_W'(2));

  for (genvar i = 0; i < NCAR; i++) begin : g_sw
    assign gate_hi[i] = ((on_cnt + LVL_W'(i)) >= LVL_W'(NCAR));
    assign gate_lo[i] = ~gate_hi[i];
  end

  // R3
  top_level_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl == 3'sd2) |-> (gate_lo == '0));

  // R3
  bottom_level_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl == -3'sd2) |-> (gate_hi == '0));

endmodule

// File: rtl/mc_overlap_pwm.sv
module mc_overlap_pwm
  import mcpwm_pkg::*;
#(
  parameter int CAR_LOG2 = 5,
  parameter int RATIO    = 21,
  parameter int AC_LOG2  = 8,
  parameter int MI_W     = 8,
  parameter int MI_FRAC  = 7,
  parameter int SIN_FRAC = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       arr_mode,
  input  logic [MI_W-1:0]  mod_index,
  output logic [NCAR-1:0]  gate_hi,
  output logic [NCAR-1:0]  gate_lo,
  output logic [LVL_W-1:0] level
);
  localparam int PERIOD = RATIO * (1 << CAR_LOG2);
  localparam int NW     = $clog2(PERIOD);
  localparam int RW     = AC_LOG2 + (MI_W - MI_FRAC) + 2;

  logic [NW-1:0]          phase;
  logic [CAR_LOG2-1:0]    car_ph;
  logic                   zc;
  arr_e                   mode_q, mode_act;
  logic [MI_W-1:0]        mi_q, mi_act;
  logic signed [RW-1:0]   ref_val;
  logic [NCAR-1:0]        above;
  logic [CNT_W-1:0]       n_above;
  logic signed [LVL_W-1:0] level_q;

  mc_timebase #(.CAR_LOG2(CAR_LOG2), .RATIO(RATIO)) u_tb (
    .clk(clk), .rst(rst), .en(en),
    .phase(phase), .car_ph(car_ph), .zc(zc)
  );

  // New settings are taken only on a zero-crossing sample.
  always_comb begin
    mode_act = (en && zc) ? arr_e'(arr_mode) : mode_q;
    mi_act   = (en && zc) ? mod_index : mi_q;
  end

  mc_sine_ref #(
    .CAR_LOG2(CAR_LOG2), .RATIO(RATIO), .AC_LOG2(AC_LOG2),
    .MI_W(MI_W), .MI_FRAC(MI_FRAC), .SIN_FRAC(SIN_FRAC), .RW(RW)
  ) u_ref (
    .clk(clk), .rst(rst), .phase(phase), .mi(mi_act), .ref_val(ref_val)
  );

  mc_carrier_bank #(.CAR_LOG2(CAR_LOG2), .AC_LOG2(AC_LOG2), .RW(RW)) u_bank (
    .clk(clk), .rst(rst), .mode(mode_act), .car_ph(car_ph),
    .ref_val(ref_val), .above(above), .n_above(n_above)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      mode_q  <= ARR_SAME;
      mi_q    <= '0;
    end else if (en) begin
      level_q <= $signed(LVL_W'(n_above) - LVL_W'(2));
      if (zc) begin
        mode_q <= mode_act;
        mi_q   <= mi_act;
      end
    end
  end

  mc_gate_map u_map (
    .clk(clk), .rst(rst), .lvl(level_q), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  assign level = level_q;

  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q >= -3'sd2) && (level_q <= 3'sd2));

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(level_q));

  // R11
  settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(en && zc) |=> ($stable(mode_q) && $stable(mi_q)));

endmodule

// File: tb/sim_mc_overlap_pwm.sv
module sim_mc_overlap_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int NPER  = 672;
  localparam int NHALF = 336;
  localparam real PI   = 3.14159265358979;

  // Stimulus/expectation table: arrangement, index, expected max and min level.
  localparam int NV = 9;
  localparam int V_MODE [NV] = '{0,   1,   2,   0,  3,  0, 1, 2, 2  };
  localparam int V_MI   [NV] = '{128, 128, 128, 64, 96, 0, 0, 0, 200};
  localparam int V_HI   [NV] = '{2,   2,   2,   2,  2,  1, 0, 0, 2  };
  localparam int V_LO   [NV] = '{-2,  -2,  -2,  -2, -2, -1, 0, 0, -2 };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] arr_mode  = 2'd0;
  logic [7:0] mod_index = 8'd0;
  logic [3:0] gate_hi, gate_lo;
  logic [2:0] level;

  int  nchk = 0, nfail = 0;
  int  bn = 0, am = 0, ami = 0;
  int  tmax = -9, tmin = 9;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mc_overlap_pwm u0 (
    .clk(clk), .rst(rst), .en(en), .arr_mode(arr_mode), .mod_index(mod_index),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .level(level)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [3:0] hi_map(input int l);
    case (l)
      2:       return 4'b1111;
      1:       return 4'b1110;
      0:       return 4'b1100;
      -1:      return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      1:       return "R7";
      2:       return "R8";
      3:       return "R9";
      default: return "R6";
    endcase
  endfunction

  // Floating-point model of the carrier stack (R4, R5).
  task automatic model(input int m, input int mi, input int n, output int cnt, output bit amb);
    real r, c;
    int  t, rmp;
    bit  inv;
    r   = (mi / 128.0) * 320.0 * $sin(2.0 * PI * n / NPER);
    t   = n % 32;
    rmp = ((t <= 16) ? t : 32 - t) * 16;
    cnt = 0;
    amb = 1'b0;
    for (int k = 0; k < 4; k++) begin
      inv = (m == 1 && k < 2) || (m == 2 && (k % 2) == 1);
      c = -320.0 + 128.0 * k + (inv ? 256.0 - rmp : 1.0 * rmp);
      if (r - c < 4.0 && c - r < 4.0) amb = 1'b1;
      if (r > c) cnt++;
    end
  endtask

  // One clock; checks the sample consumed at that edge.
  task automatic step(input string req);
    int  cnt, act_l;
    bit  amb;
    bit  was_en;
    was_en = en;
    if (was_en && (bn == 0 || bn == NHALF)) begin
      am  = arr_mode;
      ami = mod_index;
    end
    @(posedge clk);
    #1;
    act_l = $signed(level);
    if (was_en) begin
      model(am, ami, bn, cnt, amb);
      bn = (bn + 1) % NPER;
      if (!amb) begin
        // R2, R4, R5
        check(act_l == cnt - 2, req, act_l, cnt - 2);
        if (act_l > tmax) tmax = act_l;
        if (act_l < tmin) tmin = act_l;
      end
    end
    // R3
    check(gate_hi == hi_map(act_l) && gate_lo == ~hi_map(act_l), "R3 gate map",
          int'({gate_hi, gate_lo}), int'({hi_map(act_l), ~hi_map(act_l)}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual 200000 cycles expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [2:0] hold_l;
    logic [3:0] hold_h;

    // Reset state (R1)
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(level == 3'd0, "R1 reset level", int'(level), 0);
    check(gate_hi == 4'b1100, "R1 reset gate_hi", int'(gate_hi), 12);
    check(gate_lo == 4'b0011, "R1 reset gate_lo", int'(gate_lo), 3);

    // Table walk: one full reference period per entry (R2, R4..R9, R12)
    for (int i = 0; i < NV; i++) begin
      arr_mode  = 2'(V_MODE[i]);
      mod_index = 8'(V_MI[i]);
      en   = 1'b1;
      tmax = -9;
      tmin = 9;
      repeat (NPER) step(mode_tag(V_MODE[i]));
      check(tmax == V_HI[i], (V_MI[i] == 0) ? "R12 max level" : mode_tag(V_MODE[i]), tmax, V_HI[i]);
      check(tmin == V_LO[i], (V_MI[i] == 0) ? "R12 min level" : mode_tag(V_MODE[i]), tmin, V_LO[i]);
    end

    // Pause and resume (R10)
    arr_mode  = 2'd0;
    mod_index = 8'd128;
    repeat (50) step("R10 pre-pause");
    hold_l = level;
    hold_h = gate_hi;
    en = 1'b0;
    repeat (5) begin
      @(posedge clk);
      #1;
      check(level == hold_l && gate_hi == hold_h, "R10 hold", int'({level, gate_hi}), int'({hold_l, hold_h}));
    end
    en = 1'b1;
    while (bn != 0) step("R10 resume");

    // Settings change mid half-wave (R11)
    repeat (100) step("R11 before change");
    arr_mode  = 2'd1;
    mod_index = 8'd0;
    tmax = -9;
    tmin = 9;
    while (bn != NHALF) step("R11 old settings kept");
    check(tmax == 2, "R11 old settings reach +2", tmax, 2);
    tmax = -9;
    tmin = 9;
    while (bn != 0 || tmax == -9) step("R11 new settings");
    check(tmax == 0 && tmin == 0, "R11 new settings level 0", tmax * 10 + tmin, 0);

    // Reset in mid-run overrides enable (R1)
    arr_mode  = 2'd0;
    mod_index = 8'd128;
    repeat (200) step("R1 before reset");
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    check(level == 3'd0, "R1 mid-run reset level", int'(level), 0);
    check(gate_hi == 4'b1100 && gate_lo == 4'b0011, "R1 mid-run reset gates",
          int'({gate_hi, gate_lo}), int'(8'b1100_0011));
    bn  = 0;
    am  = 0;
    ami = 0;
    repeat (NPER) step("R1 restart from sample 0");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule